// File: doc/BRIEF.md
# Write Guard with Configuration Register

This block sits beside the serial protocol engine of a byte-addressed nonvolatile memory. It holds one 8-bit configuration byte and, from the current target, byte address and the two protection pins, it decides whether a write may proceed. The protocol engine asks it once per incoming data byte and withholds the acknowledge when the answer is no.

Three protection layers combine. A protect pin of programmable sense guards the main array and the one-time page together. A region of selectable size, anchored at address 0, is always read-only. The configuration byte can lock itself, and a second pin then has to be held high before it will accept a new value. The power-up contents of the configuration byte are modelled as the reset value. The unconnected level of the protect pin is logic low.

Top module: `wguard_top`

## Requirements
- R1: After reset the configuration byte reads back as 8'h00, so the region is empty, the pin sense is normal and the lock is clear.
- R2: The configuration byte reads back exactly as last written. Bit 7 is the lock flag, bit 6 is the pin sense, and bits 4:2 are the region code. Bits 5, 1 and 0 are stored but have no effect on `wr_ok`.
- R3: With pin sense 0, `wc_pin` low allows array and one-time-page writes. `wc_pin` high blocks both of them.
- R4: With pin sense 1 the meaning of `wc_pin` is inverted: high allows, low blocks.
- R5: With the lock flag clear, a `cfg_wr` pulse loads `cfg_wdata` on the next rising clock edge whatever `wcr_pin` is. A target of 2 (configuration) then gives `wr_ok`=1.
- R6: With the lock flag set, a `cfg_wr` pulse is ignored while `wcr_pin` is low, and target 2 gives `wr_ok`=0. The pulse is accepted while `wcr_pin` is high.
- R7: Region code 0 protects no address. Region code 7 makes every address of the main array read-only.
- R8: Region codes 1 to 6 make addresses 0 to 2^(code+5)-1 read-only, so the first address above that bound remains writable.
- R9: The region applies only to the main array (target 0), whatever the pins are. The one-time page (target 1) ignores the region. The configuration target ignores `wc_pin`.
- R10: `wr_ok` is combinational, following its inputs in the same cycle. Target code 3 never allows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the power-up configuration |
| wc_pin | input | 1 | Array and one-time-page protect pin; its sense is set by bit 6 |
| wcr_pin | input | 1 | Configuration unlock pin, high permits writes to a locked byte |
| tgt_sel | input | 2 | Write target: 0 array, 1 one-time page, 2 configuration, 3 none |
| addr | input | ADDR_W | Byte address within the main array |
| cfg_wr | input | 1 | Request to load the configuration byte |
| cfg_wdata | input | 8 | New configuration byte |
| wr_ok | output | 1 | Write permitted for the current target and address |
| cfg_rdata | output | 8 | Current configuration byte |

## Verification
The bench uses the default 12-bit address and 3-bit region code, which give a 4096-byte array. With this size every region bound from 64 to 2048 bytes, and the full-array case, is reachable. The bench probes the last protected address and the first free address for each code. It then crosses both pin senses with both pin levels on every target, and runs the lock and unlock sequence through the readback port.

// File: rtl/wguard_pkg.sv
package wguard_pkg;
    localparam int CFG_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        TGT_ARRAY = 2'd0,
        TGT_OTP   = 2'd1,
        TGT_CFG   = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    // Field order matches the bit positions the protocol engine decodes.
    typedef struct packed {
        logic              lock;
        logic              pol;
        logic              spare_hi;
        logic [CODE_W-1:0] code;
        logic [1:0]        spare_lo;
    } cfg_t;
endpackage

// File: rtl/wguard_cfg_reg.sv
module wguard_cfg_reg
    import wguard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);
    typedef struct packed {
        cfg_t cfg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    // An accepted write is visible on the following cycle.
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/wguard_region.sv
module wguard_region
    import wguard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] code,
    output logic              in_region
);
    localparam int NCODE = 2 ** CODE_W;

    logic [NCODE-1:0] hit;

    assign hit[0]       = 1'b0;
    assign hit[NCODE-1] = 1'b1;

    // Code i protects the lowest 2^(ADDR_W-NCODE+1+i) bytes: top bits all zero.
    for (genvar i = 1; i <= NCODE - 2; i++) begin : g_code
        assign hit[i] = (addr[ADDR_W-1 -: (NCODE-1-i)] == '0);
    end

    assign in_region = hit[code];

    // Even the largest partial region leaves the top address writable.
    always_comb begin
        if ((code != CODE_W'(NCODE - 1)) && (&addr)) begin
            p_top_free_r8: assert (!in_region);
        end
    end
endmodule

// File: rtl/wguard_top.sv
module wguard_top
    import wguard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wc_pin,
    input  logic              wcr_pin,
    input  logic [1:0]        tgt_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              wr_ok,
    output logic [CFG_W-1:0]  cfg_rdata
);
    cfg_t cfg;
    logic pin_ok;
    logic cfg_open;
    logic in_region;
    logic cfg_wr_en;

    assign pin_ok    = (wc_pin == cfg.pol);
    assign cfg_open  = !cfg.lock || wcr_pin;
    assign cfg_wr_en = cfg_wr && cfg_open;

    wguard_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .cfg_q (cfg)
    );

    wguard_region #(.ADDR_W(ADDR_W)) u_region (
        .addr      (addr),
        .code      (cfg.code),
        .in_region (in_region)
    );

    always_comb begin
        case (tgt_e'(tgt_sel))
            TGT_ARRAY: wr_ok = pin_ok && !in_region;
            TGT_OTP:   wr_ok = pin_ok;
            TGT_CFG:   wr_ok = cfg_open;
            default:   wr_ok = 1'b0;
        endcase
    end

    assign cfg_rdata = cfg;

    // Pin at its protecting level blocks array and page writes (R3, and R4 for inverted sense).
    p_pin_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((tgt_sel != 2'd2) && (wc_pin != cfg_rdata[6])) |-> !wr_ok);

    p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_rdata[7] && !wcr_pin) |=> $stable(cfg_rdata));

    p_full_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((tgt_sel == 2'd0) && (cfg_rdata[4:2] == 3'd7)) |-> !wr_ok);

    p_no_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 2'd3) |-> !wr_ok);
endmodule

// File: tb/wguard_top_bench.sv
`timescale 1ns/1ps
module wguard_top_bench;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wc_pin = 1'b0;
    logic              wcr_pin = 1'b0;
    logic [1:0]        tgt_sel = 2'd0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_wdata = 8'h00;
    logic              wr_ok;
    logic [7:0]        cfg_rdata;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    wguard_top #(.ADDR_W(ADDR_W)) u_wguard_top (
        .clk(clk), .rst_n(rst_n), .wc_pin(wc_pin), .wcr_pin(wcr_pin),
        .tgt_sel(tgt_sel), .addr(addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .wr_ok(wr_ok), .cfg_rdata(cfg_rdata)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic        wc;
        logic        wcr;
        logic [1:0]  tgt;
        logic [11:0] adr;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        // R3: normal sense
        '{8'h00, 1'b0, 1'b0, 2'd0, 12'h000, 1'b1, 4'd3},
        '{8'h00, 1'b1, 1'b0, 2'd0, 12'h000, 1'b0, 4'd3},
        '{8'h00, 1'b1, 1'b0, 2'd1, 12'h000, 1'b0, 4'd3},
        '{8'h00, 1'b0, 1'b0, 2'd1, 12'h005, 1'b1, 4'd3},
        // R4: inverted sense
        '{8'h40, 1'b1, 1'b0, 2'd0, 12'h123, 1'b1, 4'd4},
        '{8'h40, 1'b0, 1'b0, 2'd0, 12'h123, 1'b0, 4'd4},
        '{8'h40, 1'b0, 1'b0, 2'd1, 12'h000, 1'b0, 4'd4},
        '{8'h40, 1'b1, 1'b0, 2'd1, 12'h000, 1'b1, 4'd4},
        // R8: each partial region, last protected and first free address
        '{8'h04, 1'b0, 1'b0, 2'd0, 12'h03F, 1'b0, 4'd8},
        '{8'h04, 1'b0, 1'b0, 2'd0, 12'h040, 1'b1, 4'd8},
        '{8'h08, 1'b0, 1'b0, 2'd0, 12'h07F, 1'b0, 4'd8},
        '{8'h08, 1'b0, 1'b0, 2'd0, 12'h080, 1'b1, 4'd8},
        '{8'h0C, 1'b0, 1'b0, 2'd0, 12'h0FF, 1'b0, 4'd8},
        '{8'h0C, 1'b0, 1'b0, 2'd0, 12'h100, 1'b1, 4'd8},
        '{8'h10, 1'b0, 1'b0, 2'd0, 12'h1FF, 1'b0, 4'd8},
        '{8'h10, 1'b0, 1'b0, 2'd0, 12'h200, 1'b1, 4'd8},
        '{8'h14, 1'b0, 1'b0, 2'd0, 12'h3FF, 1'b0, 4'd8},
        '{8'h14, 1'b0, 1'b0, 2'd0, 12'h400, 1'b1, 4'd8},
        '{8'h18, 1'b0, 1'b0, 2'd0, 12'h7FF, 1'b0, 4'd8},
        '{8'h18, 1'b0, 1'b0, 2'd0, 12'h800, 1'b1, 4'd8},
        // R7: empty and full region
        '{8'h00, 1'b0, 1'b0, 2'd0, 12'hFFF, 1'b1, 4'd7},
        '{8'h1C, 1'b0, 1'b0, 2'd0, 12'hFFF, 1'b0, 4'd7},
        '{8'h1C, 1'b0, 1'b0, 2'd0, 12'h800, 1'b0, 4'd7},
        // R9: region is array-only, pins and region are independent
        '{8'h1C, 1'b0, 1'b0, 2'd1, 12'h000, 1'b1, 4'd9},
        '{8'h18, 1'b1, 1'b0, 2'd0, 12'h800, 1'b0, 4'd9},
        '{8'h5C, 1'b1, 1'b0, 2'd0, 12'h800, 1'b0, 4'd9},
        '{8'h00, 1'b1, 1'b0, 2'd2, 12'h000, 1'b1, 4'd9},
        // R2: spare bits set have no effect
        '{8'h23, 1'b0, 1'b0, 2'd0, 12'h000, 1'b1, 4'd2},
        // R10: no-target code
        '{8'h00, 1'b0, 1'b1, 2'd3, 12'hFFF, 1'b0, 4'd10},
        // R5 / R6: configuration target
        '{8'h00, 1'b0, 1'b0, 2'd2, 12'h000, 1'b1, 4'd5},
        '{8'h80, 1'b0, 1'b0, 2'd2, 12'h000, 1'b0, 4'd6},
        '{8'h80, 1'b1, 1'b1, 2'd2, 12'h000, 1'b1, 4'd6}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d, input logic wcr);
        @(negedge clk);
        wcr_pin   = wcr;
        cfg_wdata = d;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    initial begin
        #4000000;
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset value, low protect pin allows
        chk("R1", cfg_rdata, 8'h00);
        chk("R1", wr_ok, 1'b1);

        for (int i = 0; i < NV; i++) begin
            write_cfg(VEC[i].cfg, 1'b1);
            chk("R2", cfg_rdata, VEC[i].cfg);
            wc_pin  = VEC[i].wc;
            wcr_pin = VEC[i].wcr;
            tgt_sel = VEC[i].tgt;
            addr    = VEC[i].adr;
            #2;
            chk($sformatf("R%0d", VEC[i].req), wr_ok, VEC[i].exp);
        end

        // R2: full byte round trip
        write_cfg(8'h00, 1'b1);
        write_cfg(8'h7F, 1'b0);
        chk("R2", cfg_rdata, 8'h7F);
        // R5: unlocked write accepted with unlock pin low
        write_cfg(8'h1C, 1'b0);
        chk("R5", cfg_rdata, 8'h1C);
        // R6: locked, unlock pin low: ignored
        write_cfg(8'h9C, 1'b0);
        chk("R6", cfg_rdata, 8'h9C);
        write_cfg(8'h00, 1'b0);
        chk("R6", cfg_rdata, 8'h9C);
        tgt_sel = 2'd0; addr = 12'hFFF; wc_pin = 1'b0;
        #2;
        chk("R6", wr_ok, 1'b0);
        // R6: unlock pin high: accepted
        write_cfg(8'h00, 1'b1);
        chk("R6", cfg_rdata, 8'h00);

        // R10: same-cycle response to address change
        write_cfg(8'h04, 1'b1);
        @(posedge clk);
        #3;
        addr = 12'h000;
        #1;
        chk("R10", wr_ok, 1'b0);
        addr = 12'h040;
        #1;
        chk("R10", wr_ok, 1'b1);

        // R1: reset in mid-run restores defaults
        write_cfg(8'hDC, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R1", cfg_rdata, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", cfg_rdata, 8'h00);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule